// File: doc/BRIEF.md
# Paged Time-Slot Interchanger, Parallel to Serial

This block moves bytes from a fast parallel byte stream onto a group of serial time-division-multiplexed lanes. A frame pulse marks the start of each frame on both sides. The bytes that arrive on the parallel side during a frame are stored by arrival position in one page of a data store. During the next frame that page is read out, and another page fills. A routing table has one entry for each serial channel. The entry names the stored byte that the channel carries, or it gives a constant byte, silences the lane, or turns the lane around for that slot.

Software changes the routing table through a small write/read port. Edits go to a shadow copy. The shadow copy becomes the live table only at a frame pulse, so a frame is never built from two different tables. The serial bit rate is picked from three choices and is also taken up only at a frame pulse. Because every byte that leaves in one output frame came in during one input frame, the bytes of a channel that spans several slots stay together.

Top module: `tsi_paged_switch`

## Requirements
- R1: After reset every serial lane is undriven (`ser_oe_o`=0, `ser_dir_o`=0, `ser_o`=0), and every table entry reads back as 0x2000 (silence bit only).
- R2: A table write stores `cm_wdata_i` at index stream*CH_PER_STREAM+channel. `cm_rdata_o` combinationally shows the stored entry at `cm_addr_i`. Entry layout: bits [11:0] source slot or constant byte, bit 12 constant mode, bit 13 silence, bit 14 lane turned to input.
- R3: On the parallel side, the byte presented with `pvalid_i` in the frame-pulse cycle fills slot 0, and each later valid byte fills the next slot. A plain entry sends the byte that filled its source slot.
- R4: All channels of an output frame take their bytes from the parallel frame just before it, whatever the slot and channel order.
- R5: Each channel sends 8 bits, most significant first, and channels follow one another in index order. Bit 7 of channel 0 appears one clock after the frame-pulse edge and holds for one bit period.
- R6: With bit 12 set, the channel sends entry bits [7:0] and not a stored byte.
- R7: With bit 13 set, the lane is undriven for that channel (`ser_oe_o`=0, `ser_o`=0).
- R8: With bit 14 set, `ser_dir_o`=1 and `ser_oe_o`=0 for that channel's bits.
- R9: Precedence is bit 14 over bit 13 over bit 12.
- R10: A table write made during a frame changes the output only from the next frame pulse onward.
- R11: `rate_i` is sampled at the frame pulse: 0 gives 4 clocks per bit, 1 gives 2 clocks, 2 or 3 give 1 clock.
- R12: A plain entry whose source slot is PSLOTS or higher sends 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one per fastest bit period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_ni | input | 1 | Frame pulse, active low, one clock wide |
| rate_i | input | 2 | Serial rate code |
| pvalid_i | input | 1 | Parallel byte valid |
| pdata_i | input | 8 | Parallel byte |
| cm_we_i | input | 1 | Table write strobe |
| cm_addr_i | input | CM_AW | Table index |
| cm_wdata_i | input | 15 | Table entry to write |
| cm_rdata_o | output | 15 | Table entry at cm_addr_i (shadow copy) |
| ser_o | output | N_STREAMS | Serial data, one bit per lane |
| ser_oe_o | output | N_STREAMS | Lane output enable |
| ser_dir_o | output | N_STREAMS | Lane set to input for the current slot |

## Verification
The bench loads two different slot permutations. Each one sends late-arriving slots to early channels and early slots to late channels. Because the parallel bytes change every frame, a read from the wrong page or from a half-written page shows up as a byte from the wrong frame. One lane uses constant, silence, input and combined-flag entries, so each control bit and the order of precedence can be seen on its own. Tables written during a frame, including one write late in a long frame, show whether an edit takes effect too early. Frames at all three rates confirm bit timing and the point where a new rate takes hold.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SRC_W = 12;

  typedef struct packed {
    logic             dir_in;
    logic             hiz;
    logic             msg;
    logic [SRC_W-1:0] src;
  } cm_entry_t;

  localparam int ENTRY_W = $bits(cm_entry_t);
  localparam cm_entry_t CM_RST = '{dir_in: 1'b0, hiz: 1'b1, msg: 1'b0, src: '0};

  typedef enum logic [1:0] {
    RATE_2M = 2'd0,
    RATE_4M = 2'd1,
    RATE_8M = 2'd2
  } rate_e;

  // clocks per bit minus one
  function automatic logic [1:0] div_last(input logic [1:0] r);
    case (r)
      RATE_2M: return 2'd3;
      RATE_4M: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int CH_PER_STREAM = 64,
  parameter int PAGES         = 2,
  localparam int CH_W = (CH_PER_STREAM > 1) ? $clog2(CH_PER_STREAM) : 1,
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fp_ni,
  input  logic [1:0]      rate_i,
  output logic [CH_W-1:0] ch_o,
  output logic [2:0]      bit_o,
  output logic [1:0]      div_o,
  output logic [PG_W-1:0] wr_pg_o,
  output logic [PG_W-1:0] wr_pg_nxt_o,
  output logic [PG_W-1:0] rd_pg_o
);
  logic [CH_W-1:0] ch_q;
  logic [2:0]      bit_q;
  logic [1:0]      div_q, lim_q;
  logic [PG_W-1:0] pg_q;

  assign wr_pg_nxt_o = (pg_q == PG_W'(PAGES - 1)) ? '0 : pg_q + 1'b1;
  assign rd_pg_o     = (pg_q == '0) ? PG_W'(PAGES - 1) : pg_q - 1'b1;
  assign wr_pg_o     = pg_q;
  assign ch_o        = ch_q;
  assign bit_o       = bit_q;
  assign div_o       = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q  <= '0;
      bit_q <= '0;
      div_q <= '0;
      lim_q <= 2'd3;
      pg_q  <= '0;
    end else if (!fp_ni) begin
      ch_q  <= '0;
      bit_q <= '0;
      div_q <= '0;
      lim_q <= div_last(rate_i);
      pg_q  <= wr_pg_nxt_o;
    end else if (div_q == lim_q) begin
      div_q <= '0;
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        ch_q <= (ch_q == CH_W'(CH_PER_STREAM - 1)) ? '0 : ch_q + 1'b1;
      end
    end else begin
      div_q <= div_q + 2'd1;
    end
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int N_STREAMS = 8,
  parameter int PSLOTS    = 2430,
  parameter int PAGES     = 2,
  localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int SLOT_W = (PSLOTS > 1) ? $clog2(PSLOTS) : 1,
  localparam int CNT_W  = SLOT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  input  logic             pvalid_i,
  input  logic [7:0]       pdata_i,
  input  logic [PG_W-1:0]  wr_pg_i,
  input  logic [PG_W-1:0]  wr_pg_nxt_i,
  input  logic [PG_W-1:0]  rd_pg_i,
  input  logic [SRC_W-1:0] rd_addr_i [N_STREAMS],
  output logic [7:0]       rd_data_o [N_STREAMS]
);
  logic [7:0]      mem_q [PAGES][PSLOTS];
  logic [CNT_W-1:0] slot_q, slot_w;
  logic [PG_W-1:0]  pg_w;
  logic             wr_en;

  // the frame-pulse cycle already belongs to the new frame
  assign slot_w = fp_ni ? slot_q : '0;
  assign pg_w   = fp_ni ? wr_pg_i : wr_pg_nxt_i;
  assign wr_en  = pvalid_i && (slot_w < CNT_W'(PSLOTS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    slot_q <= '0;
    else if (wr_en) slot_q <= slot_w + 1'b1;
    else if (!fp_ni) slot_q <= '0;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[pg_w][slot_w[SLOT_W-1:0]] <= pdata_i;
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_rd
    assign rd_data_o[s] = (rd_addr_i[s] < SRC_W'(PSLOTS))
                        ? mem_q[rd_pg_i][rd_addr_i[s][SLOT_W-1:0]] : 8'h00;
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int N_STREAMS     = 8,
  parameter int CH_PER_STREAM = 64,
  localparam int DEPTH = N_STREAMS * CH_PER_STREAM,
  localparam int CM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CH_W  = (CH_PER_STREAM > 1) ? $clog2(CH_PER_STREAM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  input  logic             we_i,
  input  logic [CM_AW-1:0] addr_i,
  input  cm_entry_t        wdata_i,
  output cm_entry_t        rdata_o,
  input  logic [CH_W-1:0]  ch_i,
  output cm_entry_t        act_o [N_STREAMS]
);
  cm_entry_t shd_q [DEPTH];
  cm_entry_t act_q [DEPTH];
  logic      addr_ok;

  assign addr_ok = ({1'b0, addr_i} < (CM_AW + 1)'(DEPTH));
  assign rdata_o = addr_ok ? shd_q[addr_i] : CM_RST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) shd_q[i] <= CM_RST;
    end else if (we_i && addr_ok) begin
      shd_q[addr_i] <= wdata_i;
    end
  end

  // live table follows the shadow only at a frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) act_q[i] <= CM_RST;
    end else if (!fp_ni) begin
      act_q <= shd_q;
    end
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_act
    assign act_o[s] = act_q[CM_AW'(s * CH_PER_STREAM) + CM_AW'(ch_i)];
  end
endmodule

// File: rtl/tsi_serial_lane.sv
module tsi_serial_lane
  import tsi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cm_entry_t entry_i,
  input  logic [7:0] mem_byte_i,
  input  logic [2:0] bit_i,
  output logic      ser_o,
  output logic      oe_o,
  output logic      dir_o
);
  logic [7:0] byte_w;
  logic       drive_w;

  assign byte_w  = entry_i.msg ? entry_i.src[7:0] : mem_byte_i;
  assign drive_w = !entry_i.dir_in && !entry_i.hiz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o <= 1'b0;
      oe_o  <= 1'b0;
      dir_o <= 1'b0;
    end else begin
      ser_o <= drive_w & byte_w[3'd7 - bit_i];
      oe_o  <= drive_w;
      dir_o <= entry_i.dir_in;
    end
  end
endmodule

// File: rtl/tsi_paged_switch.sv
module tsi_paged_switch
  import tsi_pkg::*;
#(
  parameter int N_STREAMS     = 8,
  parameter int CH_PER_STREAM = 64,
  parameter int PSLOTS        = 2430,
  parameter int PAGES         = 2,
  localparam int CM_DEPTH = N_STREAMS * CH_PER_STREAM,
  localparam int CM_AW    = (CM_DEPTH > 1) ? $clog2(CM_DEPTH) : 1,
  localparam int CH_W     = (CH_PER_STREAM > 1) ? $clog2(CH_PER_STREAM) : 1,
  localparam int PG_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fp_ni,
  input  logic [1:0]           rate_i,
  input  logic                 pvalid_i,
  input  logic [7:0]           pdata_i,
  input  logic                 cm_we_i,
  input  logic [CM_AW-1:0]     cm_addr_i,
  input  logic [ENTRY_W-1:0]   cm_wdata_i,
  output logic [ENTRY_W-1:0]   cm_rdata_o,
  output logic [N_STREAMS-1:0] ser_o,
  output logic [N_STREAMS-1:0] ser_oe_o,
  output logic [N_STREAMS-1:0] ser_dir_o
);
  logic [CH_W-1:0]  tmr_ch;
  logic [2:0]       tmr_bit;
  logic [1:0]       tmr_div;
  logic [PG_W-1:0]  wr_pg, wr_pg_nxt, rd_pg;
  cm_entry_t        act   [N_STREAMS];
  cm_entry_t        rd_entry;
  logic [SRC_W-1:0] rd_addr [N_STREAMS];
  logic [7:0]       rd_data [N_STREAMS];

  tsi_frame_timer #(.CH_PER_STREAM(CH_PER_STREAM), .PAGES(PAGES)) u_tmr (
    .clk_i, .rst_ni, .fp_ni, .rate_i,
    .ch_o(tmr_ch), .bit_o(tmr_bit), .div_o(tmr_div),
    .wr_pg_o(wr_pg), .wr_pg_nxt_o(wr_pg_nxt), .rd_pg_o(rd_pg)
  );

  tsi_conn_mem #(.N_STREAMS(N_STREAMS), .CH_PER_STREAM(CH_PER_STREAM)) u_cm (
    .clk_i, .rst_ni, .fp_ni,
    .we_i(cm_we_i), .addr_i(cm_addr_i), .wdata_i(cm_entry_t'(cm_wdata_i)),
    .rdata_o(rd_entry), .ch_i(tmr_ch), .act_o(act)
  );
  assign cm_rdata_o = rd_entry;

  tsi_data_mem #(.N_STREAMS(N_STREAMS), .PSLOTS(PSLOTS), .PAGES(PAGES)) u_dm (
    .clk_i, .rst_ni, .fp_ni, .pvalid_i, .pdata_i,
    .wr_pg_i(wr_pg), .wr_pg_nxt_i(wr_pg_nxt), .rd_pg_i(rd_pg),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
    assign rd_addr[s] = act[s].src;
    tsi_serial_lane u_lane (
      .clk_i, .rst_ni,
      .entry_i(act[s]), .mem_byte_i(rd_data[s]), .bit_i(tmr_bit),
      .ser_o(ser_o[s]), .oe_o(ser_oe_o[s]), .dir_o(ser_dir_o[s])
    );
  end
endmodule

// File: rtl/tsi_paged_switch_chk.sv
module tsi_paged_switch_chk #(
  parameter int N_STREAMS = 8,
  parameter int PG_W      = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fp_ni,
  input logic [N_STREAMS-1:0] ser_o,
  input logic [N_STREAMS-1:0] ser_oe_o,
  input logic [N_STREAMS-1:0] ser_dir_o,
  input logic [1:0]           div_q,
  input logic [PG_W-1:0]      wr_pg
);
  // R5
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != 2'd0) |=> ($stable(ser_o) && $stable(ser_oe_o) && $stable(ser_dir_o)));

  // R8
  dir_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ser_dir_o & ser_oe_o) == '0));

  // R7
  undriven_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ser_o & ~ser_oe_o) == '0));

  // R4
  page_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> (wr_pg != $past(wr_pg)));

  // R4
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_ni |=> $stable(wr_pg));
endmodule

bind tsi_paged_switch tsi_paged_switch_chk #(.N_STREAMS(N_STREAMS), .PG_W(PG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_ni(fp_ni),
  .ser_o(ser_o), .ser_oe_o(ser_oe_o), .ser_dir_o(ser_dir_o),
  .div_q(tmr_div), .wr_pg(wr_pg)
);

// File: tb/sim_tsi_paged_switch.sv
module sim_tsi_paged_switch;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int CH = 4;
  localparam int PS = 16;
  localparam int NCH = NS * CH;
  localparam int NF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_n = 1'b1;
  logic [1:0]  rate = 2'd2;
  logic        pvalid = 1'b0;
  logic [7:0]  pdata = '0;
  logic        cm_we = 1'b0;
  logic [4:0]  cm_addr = '0;
  logic [14:0] cm_wdata = '0;
  logic [14:0] cm_rdata;
  logic [NS-1:0] ser, ser_oe, ser_dir;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsi_paged_switch #(.N_STREAMS(NS), .CH_PER_STREAM(CH), .PSLOTS(PS), .PAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fp_ni(fp_n), .rate_i(rate),
    .pvalid_i(pvalid), .pdata_i(pdata),
    .cm_we_i(cm_we), .cm_addr_i(cm_addr), .cm_wdata_i(cm_wdata), .cm_rdata_o(cm_rdata),
    .ser_o(ser), .ser_oe_o(ser_oe), .ser_dir_o(ser_dir)
  );

  typedef struct {
    int         s;
    int         c;
    logic [7:0] b;
    bit         oe;
    bit         dir;
    int         d;
    string      tag;
  } item_t;

  item_t       sbq[$];
  int          n_vec = 0;
  int          n_fail = 0;
  logic [14:0] shadow_m [NCH];
  logic [14:0] active_m [NCH];
  logic [7:0]  prev_data [PS];
  int          wq_addr[$];
  logic [14:0] wq_data[$];

  function automatic logic [7:0] fdata(int f, int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic item_t mk(int s, int c, logic [14:0] e, int d, string ft);
    item_t it;
    it.s = s; it.c = c; it.d = d; it.oe = 0; it.dir = 0; it.b = 8'h00;
    if (e[14]) begin
      it.dir = 1; it.tag = (e[13] | e[12]) ? "R9 R8" : "R8";
    end else if (e[13]) begin
      it.tag = e[12] ? "R9 R7" : "R7";
    end else begin
      it.oe = 1;
      if (e[12]) begin
        it.b = e[7:0]; it.tag = "R6";
      end else if (int'(e[11:0]) >= PS) begin
        it.tag = "R12";
      end else begin
        it.b = prev_data[e[3:0]]; it.tag = "R3 R4";
      end
    end
    it.tag = {it.tag, " R5", ft};
    return it;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cm_write(int a, logic [14:0] v);
    @(negedge clk);
    cm_we = 1'b1; cm_addr = 5'(a); cm_wdata = v;
    shadow_m[a] = v;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  task automatic run_frame(int f, logic [1:0] rc, int wr_start, string ft);
    int d  = (rc == 2'd0) ? 4 : (rc == 2'd1) ? 2 : 1;
    int fl = 32 * d;
    logic [7:0] cur [PS];
    for (int a = 0; a < NCH; a++) active_m[a] = shadow_m[a];
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < CH; c++)
        sbq.push_back(mk(s, c, active_m[s * CH + c], d, ft));
    for (int i = 0; i < fl; i++) begin
      @(negedge clk);
      fp_n   = (i != 0);
      rate   = rc;
      pvalid = (i < PS);
      pdata  = (i < PS) ? fdata(f, i) : 8'h00;
      if (i < PS) cur[i] = fdata(f, i);
      cm_we  = 1'b0;
      if (i >= wr_start && wq_addr.size() > 0) begin
        int a = wq_addr.pop_front();
        logic [14:0] v = wq_data.pop_front();
        cm_we = 1'b1; cm_addr = 5'(a); cm_wdata = v;
        shadow_m[a] = v;
      end
    end
    for (int i = 0; i < PS; i++) prev_data[i] = cur[i];
  endtask

  task automatic monitor();
    logic [7:0] gb [NS][CH];
    int oc [NS][CH];
    int dc [NS][CH];
    do @(posedge clk); while (fp_n !== 1'b0);
    for (int f = 0; f < NF; f++) begin
      int d = sbq[0].d;
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < CH; c++) begin
          gb[s][c] = '0; oc[s][c] = 0; dc[s][c] = 0;
        end
      for (int k = 0; k < 8 * CH; k++) begin
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
          gb[s][k / 8][7 - (k % 8)] = ser[s];
          oc[s][k / 8] += int'(ser_oe[s]);
          dc[s][k / 8] += int'(ser_dir[s]);
        end
        repeat (d - 1) @(posedge clk);
      end
      for (int n = 0; n < NCH; n++) begin
        item_t it = sbq.pop_front();
        logic [31:0] got = {8'h0, 8'(oc[it.s][it.c]), 8'(dc[it.s][it.c]), gb[it.s][it.c]};
        logic [31:0] exp = {8'h0, it.oe ? 8'd8 : 8'd0, it.dir ? 8'd8 : 8'd0, it.b};
        check($sformatf("%s frame %0d lane %0d ch %0d", it.tag, f, it.s, it.c), got, exp);
      end
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < NCH; a++) shadow_m[a] = 15'h2000;
    for (int i = 0; i < PS; i++) prev_data[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", 32'(ser_oe), 32'h0);
    check("R1 dir", 32'(ser_dir), 32'h0);
    check("R1 data", 32'(ser), 32'h0);
    cm_addr = 5'd0; #1;
    check("R1 table", 32'(cm_rdata), 32'h2000);
    cm_addr = 5'd31; #1;
    check("R1 table last", 32'(cm_rdata), 32'h2000);
    // R2 write and read back
    cm_write(9, 15'h2123);
    cm_write(30, 15'h2ABC);
    cm_addr = 5'd9; #1;
    check("R2 readback 9", 32'(cm_rdata), 32'h2123);
    cm_addr = 5'd30; #1;
    check("R2 readback 30", 32'(cm_rdata), 32'h2ABC);
    cm_addr = 5'd10; #1;
    check("R2 neighbour untouched", 32'(cm_rdata), 32'h2000);

    // program A, written during frame 0
    for (int s = 0; s < 6; s++)
      for (int c = 0; c < CH; c++) begin
        wq_addr.push_back(s * CH + c);
        wq_data.push_back(15'(((s * CH + c) * 7 + 3) % PS));
      end
    for (int c = 0; c < CH; c++) begin
      wq_addr.push_back(6 * CH + c); wq_data.push_back(15'h10A0 + 15'(c));
    end
    wq_addr.push_back(28); wq_data.push_back(15'h3055);
    wq_addr.push_back(29); wq_data.push_back(15'h4000);
    wq_addr.push_back(30); wq_data.push_back(15'h7011);
    wq_addr.push_back(31); wq_data.push_back(15'h0014);

    fork
      monitor();
      begin
        run_frame(0, 2'd1, 1, " R10");
        // program B, written during frame 1
        for (int a = 0; a < 16; a++) begin
          wq_addr.push_back(a); wq_data.push_back(15'((a * 3 + 10) % PS));
        end
        wq_addr.push_back(24); wq_data.push_back(15'h000F);
        wq_addr.push_back(29); wq_data.push_back(15'h2000);
        wq_addr.push_back(28); wq_data.push_back(15'h10C3);
        wq_addr.push_back(23); wq_data.push_back(15'h4000);
        run_frame(1, 2'd2, 1, " R10");
        run_frame(2, 2'd1, 1, " R11");
        wq_addr.push_back(0); wq_data.push_back(15'h1077);
        run_frame(3, 2'd0, 100, " R11");
        run_frame(4, 2'd3, 1, " R10 R11");
      end
    join

    @(negedge clk);
    cm_addr = 5'd0; #1;
    check("R2 readback after frames", 32'(cm_rdata), 32'h1077);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule